// File: doc/BRIEF.md
# Page-List DMA Address Walker

This block expands a storage command's two 64-bit page pointers and its byte count into an ordered series of physical (address, length) segments. No segment crosses a memory page boundary. A downstream data mover consumes the segments through a valid/ready stream. The first pointer may start anywhere inside a page. Every later segment starts on a page boundary.

When the bytes left after the first segment fit in one page, the second pointer is used directly as the last data page. When they do not fit, the second pointer is the address of a list of 8-byte page entries. The walker reads that list one entry at a time through a read request/response port, in ascending address order, with one read outstanding. All list entries are assumed to lie in one page.

The page size is chosen per command at start, as either 4 KB or 8 KB. A pulse on `done_o` ends every walk, whether it succeeded or not. `err_o` reports an alignment fault and stays set until the next accepted start.

Top module: `page_list_walker`

## Requirements
- R1: While reset is asserted and after it is released, `seg_valid_o`, `rd_req_valid_o`, `done_o` and `err_o` are all 0.
- R2: The first segment is offered one cycle after an accepted start. Its address is `ptr1_i`. Its length is the smaller of `len_i` and the number of bytes from `ptr1_i` to the end of its page.
- R3: A start with `len_i` equal to 0 produces no segment and no read. `done_o` is 1 in the cycle after the start.
- R4: When the bytes left after the first segment are nonzero and at most one page, the second and last segment is (`ptr2_i`, remaining bytes), and no read is issued.
- R5: When the bytes left after the first segment exceed one page, reads are issued to `ptr2_i + 8*k` for k = 0, 1, 2, …. Each read's response data (bits 63:0, little-endian entry) becomes the address of the next segment. A request holds its address until it is accepted.
- R6: Every list segment except the last is one full page long. The last segment carries the remaining bytes, which can be less than a page.
- R7: If a page address after the first has a nonzero offset within its page, the walker offers no further segment, issues no further read, sets `err_o` and pulses `done_o`. The page address here is either a direct `ptr2_i` or a list entry.
- R8: A list pointer with nonzero bits 2:0 sets `err_o` and ends the walk without issuing any read.
- R9: `big_page_i` = 0 selects 4096-byte pages and `big_page_i` = 1 selects 8192-byte pages. No offered segment is empty or longer than the selected page.
- R10: `done_o` is a one-cycle pulse, one cycle after the handshake of the final segment, with no segment or read offered in that cycle. `err_o` holds its value after `done_o` until the next accepted start clears it.
- R11: While a segment is offered and `seg_ready_i` is 0, the segment's address and length stay unchanged.
- R12: A start while a walk is in progress is ignored and does not alter the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| ptr1_i | input | 64 | First data pointer, any byte offset |
| ptr2_i | input | 64 | Second data page, or address of the list |
| len_i | input | 32 | Transfer length in bytes |
| big_page_i | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| seg_valid_o | output | 1 | Segment offered |
| seg_ready_i | input | 1 | Segment accepted by the consumer |
| seg_addr_o | output | 64 | Segment start address |
| seg_len_o | output | 32 | Segment length in bytes |
| rd_req_valid_o | output | 1 | List entry read request |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 64 | Byte address of the list entry |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 64 | List entry value |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Alignment fault, held until next start |

## Verification
Inputs are driven and outputs sampled on the falling clock edge.

- The first segment (R2) and the `done_o` pulse of a zero-length command (R3) are checked at the first falling edge after the start edge.
- The `done_o` pulse of a successful walk is checked at the falling edge one cycle after the final segment's handshake.
- A read response is returned one cycle after its request is accepted.
- The segment and the read address are compared on the cycle in which their handshake happens.

Some vectors withhold the ready signals on alternating cycles. This exercises the stall paths without shifting any of these sampling points.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SECOND,
      ST_REQ,
      ST_RSP,
      ST_EMIT,
      ST_DONE
   } walk_st_e;
endpackage

// File: rtl/pgw_span_calc.sv
module pgw_span_calc #(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 32,
   parameter int SMALL_LOG2 = 12,
   parameter int LARGE_LOG2 = 13
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              big_i,
   output logic [LEN_W-1:0]  page_o,
   output logic [LEN_W-1:0]  span_o,
   output logic              off_nz_o
);
   localparam logic [LEN_W-1:0] PAGE_S = LEN_W'(1) << SMALL_LOG2;
   localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(1) << LARGE_LOG2;

   logic [LARGE_LOG2-1:0] off;
   logic [LEN_W-1:0]      head;

   always_comb begin
      if (big_i) off = addr_i[LARGE_LOG2-1:0];
      else       off = {{(LARGE_LOG2-SMALL_LOG2){1'b0}}, addr_i[SMALL_LOG2-1:0]};
      page_o   = big_i ? PAGE_L : PAGE_S;
      head     = page_o - LEN_W'(off);
      span_o   = (len_i < head) ? len_i : head;
      off_nz_o = (off != '0);
   end
endmodule

// File: rtl/pgw_list_port.sv
module pgw_list_port #(
   parameter int ADDR_W      = 64,
   parameter int ENTRY_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              next_i,
   input  logic              issue_i,
   input  logic              ready_i,
   output logic              req_valid_o,
   output logic [ADDR_W-1:0] req_addr_o
);
   logic [ADDR_W-1:0] lptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lptr_q <= '0;
      else if (load_i) lptr_q <= base_i;
      else if (next_i) lptr_q <= lptr_q + ADDR_W'(ENTRY_BYTES);
   end

   assign req_valid_o = issue_i;
   assign req_addr_o  = lptr_q;

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !ready_i) |=> (req_valid_o && $stable(req_addr_o)));
endmodule

// File: rtl/page_list_walker.sv
module page_list_walker
   import pgw_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int LEN_W       = 32,
   parameter int SMALL_LOG2  = 12,
   parameter int LARGE_LOG2  = 13,
   parameter int ENTRY_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] ptr1_i,
   input  logic [ADDR_W-1:0] ptr2_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              big_page_i,
   output logic              seg_valid_o,
   input  logic              seg_ready_i,
   output logic [ADDR_W-1:0] seg_addr_o,
   output logic [LEN_W-1:0]  seg_len_o,
   output logic              rd_req_valid_o,
   input  logic              rd_req_ready_i,
   output logic [ADDR_W-1:0] rd_req_addr_o,
   input  logic              rd_rsp_valid_i,
   input  logic [ADDR_W-1:0] rd_rsp_data_i,
   output logic              done_o,
   output logic              err_o
);
   localparam int ALIGN_LOG2 = $clog2(ENTRY_BYTES);

   generate
      if (LARGE_LOG2 <= SMALL_LOG2) begin : g_bad_pages
         $error("page_list_walker: LARGE_LOG2 must exceed SMALL_LOG2");
      end
      if (LEN_W <= LARGE_LOG2 + 1) begin : g_bad_len
         $error("page_list_walker: LEN_W too narrow for a page length");
      end
      if ((1 << ALIGN_LOG2) != ENTRY_BYTES) begin : g_bad_entry
         $error("page_list_walker: ENTRY_BYTES must be a power of two");
      end
   endgenerate

   walk_st_e          st_q;
   logic [ADDR_W-1:0] seg_addr_q, ptr2_q;
   logic [LEN_W-1:0]  seg_len_q, rem_q;
   logic              big_q, err_q;

   logic [LEN_W-1:0]  page_a, span_a, page_b, span_b;
   logic              offnz_a, offnz_b;
   logic [ADDR_W-1:0] chk_addr;

   pgw_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SMALL_LOG2(SMALL_LOG2),
                   .LARGE_LOG2(LARGE_LOG2)) i_span_head (
      .addr_i(ptr1_i), .len_i(len_i), .big_i(big_page_i),
      .page_o(page_a), .span_o(span_a), .off_nz_o(offnz_a));

   assign chk_addr = (st_q == ST_FIRST) ? ptr2_q : rd_rsp_data_i;

   pgw_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SMALL_LOG2(SMALL_LOG2),
                   .LARGE_LOG2(LARGE_LOG2)) i_span_tail (
      .addr_i(chk_addr), .len_i(rem_q), .big_i(big_q),
      .page_o(page_b), .span_o(span_b), .off_nz_o(offnz_b));

   logic seg_hs, list_needed, list_aligned, lp_load, lp_next;
   assign seg_hs       = seg_valid_o && seg_ready_i;
   assign list_needed  = (rem_q > page_b);
   assign list_aligned = (ptr2_q[ALIGN_LOG2-1:0] == '0);
   assign lp_load      = (st_q == ST_FIRST) && seg_hs && list_needed && list_aligned;
   assign lp_next      = (st_q == ST_EMIT) && seg_hs && (rem_q != '0);

   pgw_list_port #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) i_list_port (
      .clk(clk), .rst_n(rst_n), .load_i(lp_load), .base_i(ptr2_q),
      .next_i(lp_next), .issue_i(st_q == ST_REQ), .ready_i(rd_req_ready_i),
      .req_valid_o(rd_req_valid_o), .req_addr_o(rd_req_addr_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         seg_addr_q <= '0;
         seg_len_q  <= '0;
         rem_q      <= '0;
         ptr2_q     <= '0;
         big_q      <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               big_q  <= big_page_i;
               ptr2_q <= ptr2_i;
               err_q  <= 1'b0;
               if (len_i == '0) begin
                  st_q <= ST_DONE;
               end else begin
                  seg_addr_q <= ptr1_i;
                  seg_len_q  <= span_a;
                  rem_q      <= len_i - span_a;
                  st_q       <= ST_FIRST;
               end
            end
            ST_FIRST: if (seg_ready_i) begin
               if (rem_q == '0) begin
                  st_q <= ST_DONE;
               end else if (!list_needed) begin
                  if (offnz_b) begin
                     err_q <= 1'b1;
                     st_q  <= ST_DONE;
                  end else begin
                     seg_addr_q <= ptr2_q;
                     seg_len_q  <= rem_q;
                     rem_q      <= '0;
                     st_q       <= ST_SECOND;
                  end
               end else if (!list_aligned) begin
                  err_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else begin
                  st_q <= ST_REQ;
               end
            end
            ST_SECOND: if (seg_ready_i) st_q <= ST_DONE;
            ST_REQ:    if (rd_req_ready_i) st_q <= ST_RSP;
            ST_RSP: if (rd_rsp_valid_i) begin
               if (offnz_b) begin
                  err_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else begin
                  seg_addr_q <= rd_rsp_data_i;
                  seg_len_q  <= span_b;
                  rem_q      <= rem_q - span_b;
                  st_q       <= ST_EMIT;
               end
            end
            ST_EMIT: if (seg_ready_i) st_q <= (rem_q == '0) ? ST_DONE : ST_REQ;
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign seg_valid_o = (st_q == ST_FIRST) || (st_q == ST_SECOND) || (st_q == ST_EMIT);
   assign seg_addr_o  = seg_addr_q;
   assign seg_len_o   = seg_len_q;
   assign done_o      = (st_q == ST_DONE);
   assign err_o       = err_q;

   logic [LEN_W-1:0] page_now;
   assign page_now = big_q ? (LEN_W'(1) << LARGE_LOG2) : (LEN_W'(1) << SMALL_LOG2);

   assert_seg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid_o && !seg_ready_i) |=> (seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o)));

   assert_seg_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid_o |-> (seg_len_o != '0 && seg_len_o <= page_now));

   assert_later_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid_o && st_q != ST_FIRST) |->
         ((seg_addr_o & ADDR_W'(page_now - LEN_W'(1))) == '0));

   assert_zero_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start_i && len_i == '0) |=> (done_o && !seg_valid_o));

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!seg_valid_o && !rd_req_valid_o));

   assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> ($stable(big_q) && $stable(ptr2_q)));
endmodule

// File: tb/test_page_list_walker.sv
module test_page_list_walker;
   typedef struct packed {
      logic [63:0] p1;
      logic [63:0] p2;
      logic [31:0] len;
      logic        big;
      logic [7:0]  bad_k;
      logic        stall;
      logic        restart;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{64'h0000_0000_1000_0100, 64'h0, 32'h0000_0200, 1'b0, 8'hFF, 1'b0, 1'b0},
      '{64'h0000_0000_2000_0000, 64'h0, 32'h0000_1000, 1'b0, 8'hFF, 1'b1, 1'b0},
      '{64'h0000_0000_3000_0F00, 64'h0000_0000_5000_0000, 32'h0000_0300, 1'b0, 8'hFF, 1'b1, 1'b0},
      '{64'h0000_0000_4000_0800, 64'h0000_0000_0060_0010, 32'h0000_2900, 1'b0, 8'hFF, 1'b0, 1'b1},
      '{64'h0000_0001_0000_1000, 64'h0000_0000_0070_0000, 32'h0000_4000, 1'b1, 8'hFF, 1'b1, 1'b0},
      '{64'h0000_0000_1234_5678, 64'h0, 32'h0000_0000, 1'b0, 8'hFF, 1'b0, 1'b0},
      '{64'h0000_0000_7000_0E00, 64'h0000_0000_8000_0010, 32'h0000_0400, 1'b0, 8'hFF, 1'b0, 1'b0},
      '{64'h0000_0000_9000_0000, 64'h0000_0000_9000_0004, 32'h0000_3000, 1'b0, 8'hFF, 1'b0, 1'b0},
      '{64'h0000_0000_A000_0000, 64'h0000_0000_0000_0B00, 32'h0000_4000, 1'b0, 8'h01, 1'b1, 1'b0},
      '{64'h0000_0000_C000_0000, 64'h0, 32'h0000_1800, 1'b1, 8'hFF, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] ptr1_i = '0, ptr2_i = '0;
   logic [31:0] len_i = '0;
   logic        big_page_i = 1'b0;
   logic        seg_ready_i = 1'b0, rd_req_ready_i = 1'b0, rd_rsp_valid_i = 1'b0;
   logic [63:0] rd_rsp_data_i = '0;
   logic        seg_valid_o, rd_req_valid_o, done_o, err_o;
   logic [63:0] seg_addr_o, rd_req_addr_o;
   logic [31:0] seg_len_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   page_list_walker i_page_list_walker (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ptr1_i(ptr1_i), .ptr2_i(ptr2_i),
      .len_i(len_i), .big_page_i(big_page_i), .seg_valid_o(seg_valid_o),
      .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
      .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
      .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
      .rd_rsp_data_i(rd_rsp_data_i), .done_o(done_o), .err_o(err_o));

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] entry_of(input logic [63:0] addr, input logic [63:0] base,
                                            input logic [7:0] bad_k);
      logic [63:0] k;
      k = (addr - base) >> 3;
      return (addr << 13) | ((k == 64'(bad_k)) ? 64'h40 : 64'h0);
   endfunction

   logic [63:0] exp_a [32];
   logic [31:0] exp_l [32];

   task automatic run_vec(input vec_t v, input int idx);
      logic [31:0] page, rem, l0, off, ln;
      logic [63:0] ent;
      int n_exp, exp_reads, got, reads, cyc, last_hs;
      logic exp_err, finished, rsp_pend;
      logic [63:0] pend_addr;
      page = v.big ? 32'd8192 : 32'd4096;
      n_exp = 0; exp_reads = 0; exp_err = 1'b0;
      if (v.len != 0) begin
         off = 32'(v.p1) & (page - 1);
         l0 = ((page - off) < v.len) ? (page - off) : v.len;
         exp_a[0] = v.p1; exp_l[0] = l0; n_exp = 1;
         rem = v.len - l0;
         if (rem != 0 && rem <= page) begin
            if ((32'(v.p2) & (page - 1)) != 0) exp_err = 1'b1;
            else begin exp_a[1] = v.p2; exp_l[1] = rem; n_exp = 2; end
         end else if (rem != 0) begin
            if (v.p2[2:0] != 3'b0) exp_err = 1'b1;
            else begin
               for (int k = 0; rem != 0 && !exp_err; k++) begin
                  ent = entry_of(v.p2 + 64'(8 * k), v.p2, v.bad_k);
                  exp_reads++;
                  if ((32'(ent) & (page - 1)) != 0) exp_err = 1'b1;
                  else begin
                     ln = (rem < page) ? rem : page;
                     exp_a[n_exp] = ent; exp_l[n_exp] = ln; n_exp++;
                     rem = rem - ln;
                  end
               end
            end
         end
      end

      @(negedge clk);
      start_i = 1'b1; ptr1_i = v.p1; ptr2_i = v.p2; len_i = v.len; big_page_i = v.big;
      @(negedge clk);
      start_i = 1'b0;
      if (v.len == 0) chk(done_o === 1'b1 && seg_valid_o === 1'b0, "R3 zero-length done", 64'(done_o), 64'd1);
      else chk(seg_valid_o === 1'b1, "R2 first segment one cycle after start", 64'(seg_valid_o), 64'd1);
      chk(err_o === 1'b0, "R10 err cleared by start", 64'(err_o), 64'd0);

      got = 0; reads = 0; cyc = 0; last_hs = -10; finished = 1'b0; rsp_pend = 1'b0; pend_addr = '0;
      while (!finished && cyc < 3000) begin
         if (done_o) begin
            finished = 1'b1;
            seg_ready_i = 1'b0; rd_req_ready_i = 1'b0; rd_rsp_valid_i = 1'b0; start_i = 1'b0;
            chk(err_o === exp_err, "R7/R8 error flag at end", 64'(err_o), 64'(exp_err));
            chk(got == n_exp, "R4/R6 segment count", 64'(got), 64'(n_exp));
            chk(reads == exp_reads, "R5/R8 read count", 64'(reads), 64'(exp_reads));
            if (!exp_err && n_exp > 0)
               chk(cyc == last_hs + 1, "R10 done one cycle after last segment", 64'(cyc), 64'(last_hs + 1));
         end else begin
            seg_ready_i = !(v.stall && cyc[0]);
            if (seg_valid_o && seg_ready_i) begin
               if (got < n_exp) begin
                  chk(seg_addr_o === exp_a[got], "R2/R4/R5 segment address", seg_addr_o, exp_a[got]);
                  chk(seg_len_o === exp_l[got], "R6/R9 segment length", 64'(seg_len_o), 64'(exp_l[got]));
               end else chk(1'b0, "R7 extra segment", 64'(got), 64'(n_exp));
               got++;
               last_hs = cyc;
            end
            rd_rsp_valid_i = rsp_pend;
            rd_rsp_data_i  = rsp_pend ? entry_of(pend_addr, v.p2, v.bad_k) : 64'h0;
            rsp_pend = 1'b0;
            rd_req_ready_i = rd_req_valid_o && !(v.stall && cyc[1]);
            if (rd_req_valid_o && rd_req_ready_i) begin
               chk(rd_req_addr_o === v.p2 + 64'(8 * reads), "R5 list read address",
                   rd_req_addr_o, v.p2 + 64'(8 * reads));
               reads++;
               rsp_pend = 1'b1;
               pend_addr = rd_req_addr_o;
            end
            if (v.restart && cyc == 2) begin
               start_i = 1'b1; len_i = 32'h0; ptr1_i = 64'hDEAD_0000; ptr2_i = 64'h0; big_page_i = 1'b1;
            end else start_i = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      if (!finished) chk(1'b0, "R10 walk did not finish", 64'(idx), 64'hFFFF);
      chk(done_o === 1'b0 && seg_valid_o === 1'b0, "R10 done is one cycle", 64'(done_o), 64'd0);
      @(negedge clk);
      chk(err_o === exp_err, "R10 error flag held after done", 64'(err_o), 64'(exp_err));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(seg_valid_o === 1'b0 && rd_req_valid_o === 1'b0, "R1 outputs idle in reset", 64'(seg_valid_o), 64'd0);
      chk(done_o === 1'b0 && err_o === 1'b0, "R1 done/err low in reset", 64'(done_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(seg_valid_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0, "R1 idle after reset",
          64'(seg_valid_o), 64'd0);
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
      // R9: same pointer and length, small page this time, splits into two segments
      run_vec('{64'h0000_0000_C000_0000, 64'h0000_0000_D000_0000, 32'h0000_1800,
                1'b0, 8'hFF, 1'b0, 1'b0}, NV);
      // R12: restart attempt during a direct two-page walk
      run_vec('{64'h0000_0000_3000_0F00, 64'h0000_0000_5000_0000, 32'h0000_0300,
                1'b0, 8'hFF, 1'b1, 1'b1}, NV + 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule